// File: doc/BRIEF.md
# Two-Line Return-to-Zero Serial Word Transmitter

This block sends 32-bit avionics data words on a pair of return-to-zero lines. A host writes the word one byte per write strobe on an 8-bit bus. It writes the byte holding bits 8..1 first and the byte holding bits 32..25 last. The serializer can start as soon as the first byte is present, so the later bytes may arrive while earlier bits are already on the line. A byte that is missing when the serializer reaches it is an underwrite. The word is then abandoned and the error is held until the host reads status.

The same host bus writes a small control register. The control register selects the bus speed, whether bit 32 carries generated odd parity or the host's own bit, and a self-test mode that keeps both lines silent while the word is still processed. An active-low enable input gates transmission. A ready flag tells the host when a fresh word may be loaded. An empty flag shows when the serializer is not sending. A single error output summarises the status register.

Top module: `serial_word_tx`

## Requirements
- R1: A synchronous active-low reset leaves `tx_ready`=1, `tx_empty`=1, `tx_err`=0, both lines low and `status_o`=8'h06. It also clears the control register, the loaded bytes and any word in progress.
- R2: Each bit is one bit period long. The first half is a pulse and the second half is low. A one pulses `txd_one` and a zero pulses `txd_zero`. The two lines are never high together and are low whenever nothing is being sent.
- R3: Bits leave in the order bit 1 first and bit 32 last. The first data byte written carries bits 8..1 with bit 1 in its LSB. The fourth byte carries bits 32..25 with bit 32 in its MSB. Bytes may be written while the word is already being sent.
- R4: With control bit 1 set, transmitted bit 32 is odd parity over bits 1..31, so the 32 bits hold an odd number of ones. With control bit 1 clear, bit 32 is the host's bit.
- R5: The pulse half of each bit lasts HALF_FAST clocks when control bit 0 is clear and HALF_SLOW clocks when it is set.
- R6: No word starts while `tx_en_n` is high. If `tx_en_n` is high at a bit boundary inside a word, the lines stay low and no further bit leaves until it returns low.
- R7: A byte that is absent when its first bit is due raises the underwrite error on `status_o[0]` and `tx_err`. The rest of the word is not sent.
- R8: The underwrite error stays set until a `status_rd` strobe. That strobe clears it unless a new underwrite occurs in the same cycle.
- R9: With control bit 2 set (self-test), both lines stay low. The flags and the error behave as in normal sending.
- R10: `tx_empty` (and `status_o[1]`) is low exactly while a word is being sent. It rises right after the low half of bit 32, or on an underwrite.
- R11: `tx_ready` (and `status_o[2]`) is high when idle with no byte loaded, and falls when a data byte is written. After a word ends it returns no sooner than four bit periods after the last bit.
- R12: A data byte written while four bytes are already loaded is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle high |
| host_ctrl_sel | input | 1 | 1: write targets control register, 0: data byte |
| host_din | input | 8 | Host write data |
| status_rd | input | 1 | Host status read strobe, clears the latched error |
| tx_en_n | input | 1 | Active-low transmit enable |
| txd_one | output | 1 | Return-to-zero line pulsed for a one bit |
| txd_zero | output | 1 | Return-to-zero line pulsed for a zero bit |
| tx_ready | output | 1 | Ready for a new word |
| tx_empty | output | 1 | Serializer not sending |
| tx_err | output | 1 | Any transmitter error latched |
| status_o | output | 8 | Status: [0] underwrite, [1] empty, [2] ready, others 0 |

## Verification
The bench first sends words whose four bytes are all present before enable, in fast parity mode and in slow data mode. Comparing the decoded word with the written one separates bit order, byte order, parity insertion and pulse length. A word whose bytes arrive during transmission shows that early start does not corrupt later bytes. A word with only its first byte shows that the underwrite stops after exactly eight bits and latches until read. Enable held high before and during a word, self-test, a fifth surplus byte and a mid-word reset each isolate one gating path. A cycle-level model checks every output on every clock.

// File: rtl/swt_pkg.sv
// Shared constants and types for the serial word transmitter.
// Assumes control and status fields sit at the fixed bit positions below.
package swt_pkg;
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_GAP  = 2'd2
    } tx_state_e;

    localparam int CTRL_W    = 3;
    localparam int CTRL_SLOW = 0;  // 1: slow bus speed
    localparam int CTRL_PAR  = 1;  // 1: bit 32 is odd parity
    localparam int CTRL_TEST = 2;  // 1: self-test, lines silent

    localparam int STAT_UW    = 0;
    localparam int STAT_EMPTY = 1;
    localparam int STAT_READY = 2;
endpackage

// File: rtl/swt_rate_gen.sv
// Half-bit clock-enable divider. Emits one half_tick every HALF_FAST or
// HALF_SLOW clocks depending on `slow`. Assumes HALF_SLOW >= HALF_FAST >= 1.
// A speed change takes effect at the next comparison; no pulse is lost.
module swt_rate_gen #(
    parameter int HALF_FAST = 2,
    parameter int HALF_SLOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    output logic half_tick
);
    localparam int CW = $clog2(HALF_SLOW) + 1;
    localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);
    localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Select the terminal count for the current speed.
    always_comb lim = slow ? LIM_SLOW : LIM_FAST;

    // Tick when the count reaches the limit.
    always_comb half_tick = (cnt_q >= lim);

    // Free-running counter that restarts on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (half_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/swt_byte_buf.sv
// Byte assembly buffer. Stores up to NBYTES host bytes in write order,
// with a valid flag per slot. `clr` empties it and takes priority over a
// write in the same cycle. Writes beyond NBYTES are dropped.
module swt_byte_buf #(
    parameter int BYTE_W = 8,
    parameter int NBYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BYTE_W-1:0]        din,
    input  logic                     clr,
    output logic [NBYTES-1:0]        slot_valid,
    output logic [NBYTES*BYTE_W-1:0] word,
    output logic                     none_loaded
);
    localparam int IW = $clog2(NBYTES + 1);
    localparam logic [IW-1:0] FULL = IW'(NBYTES);

    logic [IW-1:0] wr_idx_q;
    logic          accept;

    // A write is taken only while a slot is free and no clear is pending.
    always_comb accept = wr_en && !clr && (wr_idx_q < FULL);

    // No byte of the current word has been written yet.
    always_comb none_loaded = (wr_idx_q == '0);

    // Advance the write pointer, or rewind it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) wr_idx_q <= '0;
        else if (accept)   wr_idx_q <= wr_idx_q + 1'b1;
    end

    for (genvar s = 0; s < NBYTES; s++) begin : g_slot
        logic [BYTE_W-1:0] data_q;
        logic              val_q;

        // Capture the byte addressed by the write pointer into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                val_q  <= 1'b0;
                data_q <= '0;
            end else if (accept && (wr_idx_q == IW'(s))) begin
                val_q  <= 1'b1;
                data_q <= din;
            end
        end

        assign slot_valid[s]                   = val_q;
        assign word[s*BYTE_W +: BYTE_W]        = data_q;
    end
endmodule

// File: rtl/swt_serializer.sv
// Return-to-zero serializer. Sends word bits LSB first, one bit per two
// half ticks (pulse half, then low half). It checks at every byte boundary
// that the next byte is loaded, and raises uw_set and abandons the word if
// not. After each word or abort it inserts GAP_BITS bit periods of null.
// Assumes WORD_BITS is a multiple of BYTE_W.
module swt_serializer #(
    parameter int WORD_BITS = 32,
    parameter int BYTE_W    = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 half_tick,
    input  logic                 tx_en_n,
    input  logic                 par_sel,
    input  logic                 quiet,
    input  logic [WORD_BITS-1:0] word,
    input  logic [WORD_BITS/BYTE_W-1:0] slot_valid,
    output logic                 line_one,
    output logic                 line_zero,
    output logic                 sending,
    output logic                 idle,
    output logic                 buf_clr,
    output logic                 uw_set
);
    import swt_pkg::*;

    localparam int NBYTES = WORD_BITS / BYTE_W;
    localparam int BW     = $clog2(WORD_BITS);
    localparam int NSW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int GHALF  = 2 * GAP_BITS;
    localparam int GW     = (GHALF > 1) ? $clog2(GHALF) : 1;
    localparam logic [BW-1:0] LAST     = BW'(WORD_BITS - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GHALF - 1);

    tx_state_e     st_q;
    logic [BW-1:0] bit_q;
    logic          low_q;
    logic [GW-1:0] gap_q;

    logic [BW-1:0]  nxt_bit;
    logic [NSW-1:0] nxt_slot;
    logic           at_boundary;
    logic           cur_bit;
    logic           bit_end;
    logic           word_done;

    // Index, slot and boundary test for the bit after the current one.
    always_comb begin
        nxt_bit     = bit_q + BW'(1);
        nxt_slot    = NSW'(32'(nxt_bit) / BYTE_W);
        at_boundary = ((32'(nxt_bit) % BYTE_W) == 0);
    end

    // Value of the bit on the line; the top bit may be replaced by parity.
    always_comb begin
        if (par_sel && (bit_q == LAST)) cur_bit = ~^word[WORD_BITS-2:0];
        else                            cur_bit = word[bit_q];
    end

    // End-of-bit events: normal finish and underwrite abort.
    always_comb begin
        bit_end   = (st_q == TX_SEND) && half_tick && low_q;
        word_done = bit_end && (bit_q == LAST);
        uw_set    = bit_end && (bit_q != LAST) && !tx_en_n
                    && at_boundary && !slot_valid[nxt_slot];
        buf_clr   = word_done || uw_set;
    end

    // Line drivers and state flags.
    always_comb begin
        sending   = (st_q == TX_SEND);
        idle      = (st_q == TX_IDLE);
        line_one  = sending && !low_q && cur_bit  && !quiet;
        line_zero = sending && !low_q && !cur_bit && !quiet;
    end

    // Word sequencing: start, half-bit phases, hold, abort and null gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TX_IDLE;
            bit_q <= '0;
            low_q <= 1'b0;
            gap_q <= '0;
        end else if (half_tick) begin
            unique case (st_q)
                TX_IDLE: begin
                    if (slot_valid[0] && !tx_en_n) begin
                        st_q  <= TX_SEND;
                        bit_q <= '0;
                        low_q <= 1'b0;
                    end
                end
                TX_SEND: begin
                    if (!low_q) begin
                        low_q <= 1'b1;
                    end else if (word_done || uw_set) begin
                        st_q  <= TX_GAP;
                        gap_q <= '0;
                        low_q <= 1'b0;
                    end else if (!tx_en_n) begin
                        bit_q <= nxt_bit;
                        low_q <= 1'b0;
                    end
                end
                TX_GAP: begin
                    if (gap_q == GAP_LAST) st_q  <= TX_IDLE;
                    else                   gap_q <= gap_q + 1'b1;
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_word_tx.sv
// Top of the serial word transmitter. Decodes host writes into the control
// register or the byte buffer, latches the underwrite error until a status
// read, and assembles status and handshake flags. Assumes one host access
// per strobe cycle.
module serial_word_tx #(
    parameter int BYTE_W    = 8,
    parameter int WORD_BITS = 32,
    parameter int HALF_FAST = 2,
    parameter int HALF_SLOW = 8,
    parameter int GAP_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_ctrl_sel,
    input  logic [BYTE_W-1:0] host_din,
    input  logic              status_rd,
    input  logic              tx_en_n,
    output logic              txd_one,
    output logic              txd_zero,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              tx_err,
    output logic [BYTE_W-1:0] status_o
);
    import swt_pkg::*;

    localparam int NBYTES = WORD_BITS / BYTE_W;

    logic [CTRL_W-1:0]    ctrl_q;
    logic                 err_q;
    logic                 half_tick;
    logic [NBYTES-1:0]    slot_valid;
    logic [WORD_BITS-1:0] word;
    logic                 none_loaded;
    logic                 buf_clr;
    logic                 uw_set;
    logic                 sending;
    logic                 idle;

    // Control register write from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)                       ctrl_q <= '0;
        else if (host_wr && host_ctrl_sel) ctrl_q <= host_din[CTRL_W-1:0];
    end

    // Sticky underwrite error; a new error wins over a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (uw_set)    err_q <= 1'b1;
        else if (status_rd) err_q <= 1'b0;
    end

    swt_rate_gen #(
        .HALF_FAST (HALF_FAST),
        .HALF_SLOW (HALF_SLOW)
    ) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow      (ctrl_q[CTRL_SLOW]),
        .half_tick (half_tick)
    );

    swt_byte_buf #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (host_wr && !host_ctrl_sel),
        .din         (host_din),
        .clr         (buf_clr),
        .slot_valid  (slot_valid),
        .word        (word),
        .none_loaded (none_loaded)
    );

    swt_serializer #(
        .WORD_BITS (WORD_BITS),
        .BYTE_W    (BYTE_W),
        .GAP_BITS  (GAP_BITS)
    ) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .tx_en_n    (tx_en_n),
        .par_sel    (ctrl_q[CTRL_PAR]),
        .quiet      (ctrl_q[CTRL_TEST]),
        .word       (word),
        .slot_valid (slot_valid),
        .line_one   (txd_one),
        .line_zero  (txd_zero),
        .sending    (sending),
        .idle       (idle),
        .buf_clr    (buf_clr),
        .uw_set     (uw_set)
    );

    // Handshake flags and status word.
    always_comb begin
        tx_empty             = !sending;
        tx_ready             = idle && none_loaded;
        tx_err               = err_q;
        status_o             = '0;
        status_o[STAT_UW]    = err_q;
        status_o[STAT_EMPTY] = tx_empty;
        status_o[STAT_READY] = tx_ready;
    end
endmodule

// File: rtl/swt_checker.sv
// Protocol checker for serial_word_tx, bound to every instance.
module swt_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_en_n,
    input logic status_rd,
    input logic self_test,
    input logic txd_one,
    input logic txd_zero,
    input logic tx_ready,
    input logic tx_empty,
    input logic tx_err
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (tx_ready && tx_empty && !tx_err && !txd_one && !txd_zero));

    assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(txd_one && txd_zero));

    assert_hold_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_n && tx_empty) |=> tx_empty);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && !status_rd) |=> tx_err);

    assert_selftest_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        self_test |-> (!txd_one && !txd_zero));

    assert_empty_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (!txd_one && !txd_zero));

    assert_ready_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_empty);
endmodule

bind serial_word_tx swt_checker u_swt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en_n   (tx_en_n),
    .status_rd (status_rd),
    .self_test (ctrl_q[swt_pkg::CTRL_TEST]),
    .txd_one   (txd_one),
    .txd_zero  (txd_zero),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty),
    .tx_err    (tx_err)
);

// File: tb/tb_serial_word_tx.sv
module tb_serial_word_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HF = 2;
    localparam int HS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_ctrl_sel = 1'b0;
    logic [7:0] host_din = '0;
    logic       status_rd = 1'b0;
    logic       tx_en_n = 1'b1;
    logic       txd_one, txd_zero, tx_ready, tx_empty, tx_err;
    logic [7:0] status_o;

    int n_checks = 0;
    int n_fail   = 0;

    serial_word_tx #(.HALF_FAST(HF), .HALF_SLOW(HS)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ctrl_sel(host_ctrl_sel),
        .host_din(host_din), .status_rd(status_rd), .tx_en_n(tx_en_n),
        .txd_one(txd_one), .txd_zero(txd_zero), .tx_ready(tx_ready),
        .tx_empty(tx_empty), .tx_err(tx_err), .status_o(status_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] mq[$];
    int  mcnt = 0, mstate = 0, mbit = 0, mlow = 0, mgap = 0;
    logic [2:0] mctrl = '0;
    logic merr = 1'b0;
    logic armed = 1'b0;

    always @(posedge clk) begin
        int  h;
        bit  tick, clr, seterr;
        if (!rst_n) begin
            mq.delete(); mcnt = 0; mstate = 0; mbit = 0; mlow = 0; mgap = 0;
            mctrl = '0; merr = 1'b0; armed = 1'b1;
        end else begin
            h = mctrl[0] ? HS : HF;
            tick = (mcnt >= h - 1);
            clr = 0; seterr = 0;
            if (tick) begin
                if (mstate == 0) begin
                    if (mq.size() > 0 && !tx_en_n) begin mstate = 1; mbit = 0; mlow = 0; end
                end else if (mstate == 1) begin
                    if (mlow == 0) mlow = 1;
                    else if (mbit == 31) begin clr = 1; mstate = 2; mgap = 0; mlow = 0; end
                    else if (tx_en_n) begin end
                    else if (((mbit + 1) % 8 == 0) && (mq.size() <= (mbit + 1) / 8)) begin
                        seterr = 1; clr = 1; mstate = 2; mgap = 0; mlow = 0;
                    end else begin mbit++; mlow = 0; end
                end else begin
                    if (mgap == 7) mstate = 0; else mgap++;
                end
            end
            mcnt = tick ? 0 : mcnt + 1;
            if (clr) mq.delete();
            else if (host_wr && !host_ctrl_sel && mq.size() < 4) mq.push_back(host_din);
            if (host_wr && host_ctrl_sel) mctrl = host_din[2:0];
            if (seterr) merr = 1'b1; else if (status_rd) merr = 1'b0;
        end
    end

    always @(negedge clk) begin
        logic bv, e1, e0, er, ee;
        logic [31:0] w;
        if (armed) begin
            bv = 1'b0;
            if (mstate == 1 && mq.size() > mbit / 8) begin
                if (mbit == 31 && mctrl[1]) begin
                    w = {mq[3], mq[2], mq[1], mq[0]};
                    bv = ~^w[30:0];
                end else bv = mq[mbit/8][mbit%8];
            end
            e1 = (mstate == 1) && (mlow == 0) && bv && !mctrl[2];
            e0 = (mstate == 1) && (mlow == 0) && !bv && !mctrl[2];
            ee = (mstate != 1);
            er = (mstate == 0) && (mq.size() == 0);
            chk("R2 txd_one model", txd_one, e1);
            chk("R2 txd_zero model", txd_zero, e0);
            chk("R10 tx_empty model", tx_empty, ee);
            chk("R11 tx_ready model", tx_ready, er);
            chk("R7 tx_err model", tx_err, merr);
            chk("R8 status model", status_o, {5'b0, er, ee, merr});
        end
    end

    // ---------------- line decoder ----------------
    logic [31:0] dec_word;
    int dec_n = 0, hi_len = 0, last_w = 0;
    logic p1 = 0, p0 = 0, saw_busy = 0;

    always @(negedge clk) begin
        if (txd_one && !p1 && dec_n < 32)  begin dec_word[dec_n] = 1'b1; dec_n++; end
        if (txd_zero && !p0 && dec_n < 32) begin dec_word[dec_n] = 1'b0; dec_n++; end
        if (txd_one || txd_zero) hi_len++;
        else if (hi_len != 0) begin last_w = hi_len; hi_len = 0; end
        if (!tx_empty) saw_busy = 1;
        p1 = txd_one; p0 = txd_zero;
    end

    task automatic dec_clear();
        dec_n = 0; dec_word = '0; saw_busy = 0;
    endtask

    task automatic wr_ctrl(input logic [2:0] v);
        @(negedge clk); host_wr = 1; host_ctrl_sel = 1; host_din = {5'b0, v};
        @(negedge clk); host_wr = 0; host_ctrl_sel = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); host_wr = 1; host_ctrl_sel = 0; host_din = b;
        @(negedge clk); host_wr = 0;
    endtask

    task automatic wr_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) wr_byte(w[i*8 +: 8]);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000 && !tx_ready; i++) @(negedge clk);
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [31:0] w;
        int gap;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ready after reset", tx_ready, 1);
        chk("R1 empty after reset", tx_empty, 1);
        chk("R1 err after reset", tx_err, 0);
        chk("R1 lines after reset", {txd_one, txd_zero}, 0);
        chk("R1 status after reset", status_o, 8'h06);

        // fast, parity: all bytes before enable
        wr_ctrl(3'b010);
        dec_clear();
        w = 32'h5A3C_E196;
        wr_byte(w[7:0]);
        chk("R11 ready falls on byte write", tx_ready, 0);
        wr_byte(w[15:8]); wr_byte(w[23:16]); wr_byte(w[31:24]);
        tx_en_n = 0;
        for (int i = 0; i < 5000 && tx_empty; i++) @(negedge clk);
        for (int i = 0; i < 5000 && !tx_empty; i++) @(negedge clk);
        chk("R10 ready still low when empty rises", tx_ready, 0);
        gap = 0;
        while (!tx_ready && gap < 5000) begin gap++; @(negedge clk); end
        chk("R11 gap at least four bit periods", (gap >= 8 * HF), 1);
        chk("R3 bit count", dec_n, 32);
        chk("R4 parity word", dec_word, {~^w[30:0], w[30:0]});
        chk("R5 fast pulse width", last_w, HF);

        // slow, data bit 32
        wr_ctrl(3'b001);
        dec_clear();
        w = 32'h8000_0F01;
        wr_word(w);
        idle_n(4); wait_ready();
        chk("R4 data word bit 32 from host", dec_word, w);
        chk("R5 slow pulse width", last_w, HS);

        // on-the-fly loading
        wr_ctrl(3'b010);
        dec_clear();
        w = 32'h1234_5678;
        wr_byte(w[7:0]);
        for (int i = 1; i < 4; i++) begin idle_n(18); wr_byte(w[i*8 +: 8]); end
        idle_n(4); wait_ready();
        chk("R3 on-the-fly word", dec_word, {~^w[30:0], w[30:0]});
        chk("R7 no error when bytes arrive in time", tx_err, 0);

        // underwrite
        dec_clear();
        wr_byte(8'hC3);
        idle_n(4); wait_ready();
        chk("R7 underwrite stops after first byte", dec_n, 8);
        chk("R7 error latched", tx_err, 1);
        chk("R7 status bit 0", status_o[0], 1);
        idle_n(40);
        chk("R8 error held without read", tx_err, 1);
        @(negedge clk); status_rd = 1; @(negedge clk); status_rd = 0;
        chk("R8 error cleared by read", tx_err, 0);

        // enable gating
        tx_en_n = 1;
        dec_clear();
        w = 32'hF0F0_A55A;
        wr_word(w);
        idle_n(100);
        chk("R6 no start while disabled", tx_empty, 1);
        chk("R6 no bits while disabled", dec_n, 0);
        tx_en_n = 0;
        for (int i = 0; i < 5000 && dec_n < 12; i++) @(negedge clk);
        tx_en_n = 1;
        idle_n(6);
        gap = dec_n;
        idle_n(40);
        chk("R6 no bit while held mid-word", dec_n, gap);
        tx_en_n = 0;
        wait_ready();
        chk("R6 word intact after hold", dec_word, {~^w[30:0], w[30:0]});

        // self-test
        wr_ctrl(3'b110);
        dec_clear();
        wr_word(32'hFFFF_FFFF);
        idle_n(4); wait_ready();
        chk("R9 self-test still processes word", saw_busy, 1);
        chk("R9 self-test silent lines", dec_n, 0);

        // surplus fifth byte
        wr_ctrl(3'b000);
        tx_en_n = 1;
        dec_clear();
        w = 32'h0102_0304;
        wr_word(w);
        wr_byte(8'hEE);
        tx_en_n = 0;
        idle_n(4); wait_ready();
        chk("R12 fifth byte ignored", dec_word, w);
        chk("R12 bit count", dec_n, 32);

        // reset during a word
        dec_clear();
        wr_word(32'hAAAA_5555);
        idle_n(30);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R1 ready after mid-word reset", tx_ready, 1);
        chk("R1 empty after mid-word reset", tx_empty, 1);
        gap = dec_n;
        idle_n(200);
        chk("R1 word discarded by reset", dec_n, gap);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule